// File: doc/BRIEF.md
# Selectable-Depth Unanimous Input Filter

This block removes short disturbances from slow input pins. It holds four shared filter settings. Each setting combines a depth code with a sampling tap, and the tap names one bit of a free-running 32-bit system counter. Every pin in the block selects one of the four settings through its own select field. Whenever the chosen counter bit changes level, the pin's current level moves into the newest stage of that pin's shift chain. The filtered level goes high only when every active stage holds 1, and goes low only when every active stage holds 0. In every other case it keeps its previous value.

A configuration write port rewrites one setting at a time. This lets software-facing logic trade response time against noise rejection. The depth can be 2, 3, 5 or 8 samples, and the sample spacing can be any power of two between 1 and 2^31 clocks. The pin inputs must already be synchronous to `clk`, and the counter comes from outside the block.

Top module: `glitch_filter_bank`

## Requirements
- R1: The reset is synchronous and active low. After reset, every filtered output is 0 and every shift chain holds zeros, so a pin needs a full depth of 1 samples before its output rises.
- R2: After reset, the four settings are as follows. Setting 0 has depth code 0 and tap 0. Setting 1 has depth code 1 and tap 5. Setting 2 has depth code 2 and tap 19. Setting 3 has depth code 3 and tap 22.
- R3: Depth codes 0, 1, 2 and 3 select 2, 3, 5 and 8 active stages. Starting from an all-zero chain, the output rises on exactly that number of consecutive 1 samples.
- R4: A tap value n (0..31) selects bit n of `ct_in`. A sample is taken at the clock edge where that bit differs from its registered value of the previous cycle, so rising and falling changes both count. After reset, the registered copy is 0. With a counter that increments by one each clock, tap n yields one sample every 2^n clocks.
- R5: Changes on counter bits other than a setting's selected tap cause no samples for the pins that use that setting.
- R6: The output becomes 1 only when all active stages are 1, and becomes 0 only when all are 0. A run of differing samples shorter than the depth leaves the output unchanged.
- R7: When `cfg_wr_en` is high at a clock edge, the setting indexed by `cfg_wr_idx` takes `cfg_wr_len` and `cfg_wr_tap` from that edge on. The other settings keep their values.
- R8: Rewriting a setting does not clear any chain. Only the newest stages, as many as the current depth, take part in the agreement test. As a result, shrinking the depth can move the output on the edge after the write without a new sample.
- R9: Pin p uses the setting given by `pin_sel[2p+1:2p]`. Each pin has its own chain and output, and a sample on one setting does not affect pins that select a different setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NPIN | Synchronized pin levels |
| ct_in | input | 32 | Low bits of the free-running counter |
| cfg_wr_en | input | 1 | Setting write strobe |
| cfg_wr_idx | input | 2 | Setting to rewrite |
| cfg_wr_len | input | 2 | New depth code |
| cfg_wr_tap | input | 5 | New tap bit index |
| pin_sel | input | 2*NPIN | Setting select per pin, two bits each |
| level_out | output | NPIN | Filtered levels |

## Verification
A sample is taken at the rising edge where the selected counter bit has changed, and the filtered output moves at that same edge. A rewritten depth first applies at the edge after the write. The bench changes inputs on falling edges and reads outputs on the next falling edge. For counted responses, it adds one idle cycle after each tap change, so every reading falls after the edge that consumed the sample. A cycle-level model in the bench, built from the requirements, is compared against both outputs at every falling edge. Directed counts then confirm the number of samples or clocks that each depth and tap needs before the output rises.

// File: rtl/glf_pkg.sv
// Shared constants, setting type and depth decoding for the input filter bank.
// Assumes a 32-bit counter slice and four shared settings.
package glf_pkg;
    localparam int unsigned CT_W       = 32;
    localparam int unsigned TAP_W      = $clog2(CT_W);
    localparam int unsigned NSET       = 4;
    localparam int unsigned SET_W      = $clog2(NSET);
    localparam int unsigned LEN_W      = 2;
    localparam int unsigned MAX_STAGES = 8;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [TAP_W-1:0] tap;
    } filt_cfg_t;

    // Active-stage mask for a depth code: 2, 3, 5 or 8 newest stages.
    function automatic logic [MAX_STAGES-1:0] stage_mask(input logic [LEN_W-1:0] code);
        case (code)
            2'd0:    stage_mask = 8'h03;
            2'd1:    stage_mask = 8'h07;
            2'd2:    stage_mask = 8'h1F;
            default: stage_mask = 8'hFF;
        endcase
    endfunction

    // Reset value of each shared setting.
    function automatic filt_cfg_t default_cfg(input int unsigned idx);
        case (idx)
            0:       default_cfg = '{len: LEN_W'(0), tap: TAP_W'(0)};
            1:       default_cfg = '{len: LEN_W'(1), tap: TAP_W'(5)};
            2:       default_cfg = '{len: LEN_W'(2), tap: TAP_W'(19)};
            default: default_cfg = '{len: LEN_W'(3), tap: TAP_W'(22)};
        endcase
    endfunction
endpackage

// File: rtl/glf_cfg_bank.sv
// Holds the shared filter settings and applies single-setting writes.
// Assumes one write per clock at most; writes take effect at the edge.
module glf_cfg_bank
    import glf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SET_W-1:0]       wr_idx,
    input  logic [LEN_W-1:0]       wr_len,
    input  logic [TAP_W-1:0]       wr_tap,
    output filt_cfg_t [NSET-1:0]   cfg_o
);
    logic seen_q;

    // Marks that at least one edge has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    for (genvar k = 0; k < NSET; k++) begin : g_set
        // Setting register k: defaults on reset, loads on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_o[k] <= default_cfg(k);
            else if (wr_en && wr_idx == SET_W'(k))
                cfg_o[k] <= '{len: wr_len, tap: wr_tap};
        end

        p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && $past(wr_en) && $past(wr_idx) == SET_W'(k))
            |-> (cfg_o[k].len == $past(wr_len) && cfg_o[k].tap == $past(wr_tap)));

        p_others_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && !($past(wr_en) && $past(wr_idx) == SET_W'(k)))
            |-> $stable(cfg_o[k]));
    end
endmodule

// File: rtl/glf_tap_strobe.sv
// Picks one counter bit and flags each change of it as a sample strobe.
// Assumes ct_in is synchronous to clk; a tap change may give one extra strobe.
module glf_tap_strobe
    import glf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CT_W-1:0]  ct_in,
    input  logic [TAP_W-1:0] tap_sel,
    output logic             strobe
);
    logic tap_bit;
    logic prev_q;

    assign tap_bit = ct_in[tap_sel];
    assign strobe  = tap_bit ^ prev_q;

    // Keeps last cycle's level of the selected bit.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= tap_bit;
    end
endmodule

// File: rtl/glf_chain.sv
// Per-pin sample chain with unanimous-agreement output.
// Assumes strobe and depth code come from the pin's selected setting.
module glf_chain
    import glf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_pin,
    input  logic             smp_stb,
    input  logic [LEN_W-1:0] len_code,
    output logic             level
);
    logic [MAX_STAGES-1:0] chain_q;
    logic [MAX_STAGES-1:0] chain_d;
    logic [MAX_STAGES-1:0] act_mask;
    logic                  all_hi;
    logic                  all_lo;
    logic                  seen_q;

    // Next chain: newest sample enters stage 0 on a strobe.
    always_comb begin
        chain_d = smp_stb ? {chain_q[MAX_STAGES-2:0], smp_pin} : chain_q;
        act_mask = stage_mask(len_code);
        all_hi   = (chain_d & act_mask) == act_mask;
        all_lo   = (chain_d & act_mask) == '0;
    end

    // Chain and output registers; output holds unless stages agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            level   <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            seen_q  <= 1'b1;
            if (all_hi)      level <= 1'b1;
            else if (all_lo) level <= 1'b0;
        end
    end

    p_rise_unanimous_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $rose(level))
        |-> ((chain_q & stage_mask($past(len_code))) == stage_mask($past(len_code))));

    p_fall_unanimous_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $fell(level))
        |-> ((chain_q & stage_mask($past(len_code))) == '0));

    p_sample_enters_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(smp_stb)) |-> (chain_q[0] == $past(smp_pin)));

    p_no_strobe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(smp_stb)) |-> $stable(chain_q));
endmodule

// File: rtl/glitch_filter_bank.sv
// Filter bank top: shared settings, one strobe per setting, one chain per pin.
// Assumes pin_in is already synchronized and ct_in counts freely.
module glitch_filter_bank
    import glf_pkg::*;
#(
    parameter int unsigned NPIN = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPIN-1:0]       pin_in,
    input  logic [CT_W-1:0]       ct_in,
    input  logic                  cfg_wr_en,
    input  logic [SET_W-1:0]      cfg_wr_idx,
    input  logic [LEN_W-1:0]      cfg_wr_len,
    input  logic [TAP_W-1:0]      cfg_wr_tap,
    input  logic [NPIN*SET_W-1:0] pin_sel,
    output logic [NPIN-1:0]       level_out
);
    filt_cfg_t [NSET-1:0] cfg;
    logic      [NSET-1:0] set_stb;

    glf_cfg_bank u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wr_idx (cfg_wr_idx),
        .wr_len (cfg_wr_len),
        .wr_tap (cfg_wr_tap),
        .cfg_o  (cfg)
    );

    for (genvar s = 0; s < NSET; s++) begin : g_strobe
        glf_tap_strobe u_ts (
            .clk     (clk),
            .rst_n   (rst_n),
            .ct_in   (ct_in),
            .tap_sel (cfg[s].tap),
            .strobe  (set_stb[s])
        );
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [SET_W-1:0] sel;
        logic             stb;
        logic [LEN_W-1:0] len;

        // Routes the selected setting's strobe and depth to this pin.
        always_comb begin
            sel = pin_sel[p*SET_W +: SET_W];
            stb = set_stb[sel];
            len = cfg[sel].len;
        end

        glf_chain u_chain (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_pin  (pin_in[p]),
            .smp_stb  (stb),
            .len_code (len),
            .level    (level_out[p])
        );
    end
endmodule

// File: tb/glitch_filter_bank_test.sv
module glitch_filter_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NPIN = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPIN-1:0]   pin_in = '0;
    logic [31:0]       ct_in = '0;
    logic              cfg_wr_en = 1'b0;
    logic [1:0]        cfg_wr_idx = '0;
    logic [1:0]        cfg_wr_len = '0;
    logic [4:0]        cfg_wr_tap = '0;
    logic [2*NPIN-1:0] pin_sel = '0;
    logic [NPIN-1:0]   level_out;

    glitch_filter_bank #(.NPIN(NPIN)) uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ct_in(ct_in),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_len(cfg_wr_len),
        .cfg_wr_tap(cfg_wr_tap), .pin_sel(pin_sel), .level_out(level_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    // Staged input values, applied on falling edges.
    logic [31:0]       ct_r = '0;
    logic [NPIN-1:0]   pin_r = '0;
    logic [2*NPIN-1:0] sel_r = '0;
    logic              we_r = 0;
    logic [1:0]        widx_r = '0, wlen_r = '0;
    logic [4:0]        wtap_r = '0;

    // Reference model from the requirements.
    int  m_len [4];
    int  m_tap [4];
    bit  m_prev [4];
    bit  m_stb [4];
    bit [7:0] m_chain [NPIN];
    bit  m_out [NPIN];
    bit  model_live = 0;

    function automatic int nstages(input int code);
        case (code) 0: return 2; 1: return 3; 2: return 5; default: return 8; endcase
    endfunction

    function automatic int dflt_tap(input int s);
        case (s) 0: return 0; 1: return 5; 2: return 19; default: return 22; endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 4; s++) begin
                m_len[s] = s; m_tap[s] = dflt_tap(s); m_prev[s] = 0;
            end
            for (int p = 0; p < NPIN; p++) begin m_chain[p] = 0; m_out[p] = 0; end
            model_live = 1;
        end else begin
            for (int s = 0; s < 4; s++) begin
                m_stb[s]  = (ct_in[m_tap[s]] != m_prev[s]);
                m_prev[s] = ct_in[m_tap[s]];
            end
            for (int p = 0; p < NPIN; p++) begin
                int sp; int msk;
                sp = int'(pin_sel[2*p +: 2]);
                if (m_stb[sp]) m_chain[p] = {m_chain[p][6:0], pin_in[p]};
                msk = (1 << nstages(m_len[sp])) - 1;
                if ((int'(m_chain[p]) & msk) == msk) m_out[p] = 1;
                else if ((int'(m_chain[p]) & msk) == 0) m_out[p] = 0;
            end
            if (cfg_wr_en) begin
                m_len[cfg_wr_idx] = int'(cfg_wr_len);
                m_tap[cfg_wr_idx] = int'(cfg_wr_tap);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            if (fails <= 30) $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: compare outputs with model, then drive staged inputs.
    task automatic cyc();
        @(negedge clk);
        if (model_live && rst_n)
            for (int p = 0; p < NPIN; p++)
                chk(level_out[p] == m_out[p], cur_req, $sformatf("model pin%0d", p),
                    int'(level_out[p]), int'(m_out[p]));
        ct_in = ct_r; pin_in = pin_r; pin_sel = sel_r;
        cfg_wr_en = we_r; cfg_wr_idx = widx_r; cfg_wr_len = wlen_r; cfg_wr_tap = wtap_r;
    endtask

    task automatic wr(input int idx, input int len, input int tap);
        we_r = 1; widx_r = 2'(idx); wlen_r = 2'(len); wtap_r = 5'(tap);
        cyc();
        we_r = 0;
        cyc();
    endtask

    // Toggle a tap bit, then idle one cycle so the result is visible.
    task automatic smp(input int tap, input bit b);
        pin_r = {NPIN{b}};
        ct_r[tap] = ~ct_r[tap];
        cyc(); cyc();
    endtask

    // Samples of 1 needed on pin0 before its output rises, from a cleared chain.
    task automatic rise_count(input int tap, output int n);
        n = 0;
        for (int i = 0; i < 10; i++) smp(tap, 0);
        for (int k = 1; k <= 12; k++) begin
            smp(tap, 1);
            if (level_out[0] && n == 0) n = k;
        end
    endtask

    task automatic do_reset();
        rst_n = 0; ct_r = '0; pin_r = '0;
        cyc(); cyc();
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int first;
        bit [31:0] lf;
        sel_r = {2'd1, 2'd0};
        do_reset();
        cyc();
        // R1: reset clears outputs
        cur_req = "R1";
        chk(level_out == '0, "R1", "output after reset", int'(level_out), 0);
        for (int i = 0; i < 3; i++) smp(0, 1);
        // R1: after reset the chain starts at zeros, depth-2 needs both samples
        do_reset(); cyc();
        pin_r = '1; ct_r[0] = 1; cyc(); cyc();
        chk(level_out[0] == 0, "R1", "one sample after reset", int'(level_out[0]), 0);

        // R2: default settings, observed through depth and tap
        cur_req = "R2";
        for (int s = 0; s < 4; s++) begin
            sel_r = {2'(s), 2'(s)};
            rise_count(dflt_tap(s), n);
            chk(n == nstages(s), "R2", $sformatf("default set%0d samples", s), n, nstages(s));
        end

        // R3: each depth code on rewritten setting 0 with varied taps
        cur_req = "R3";
        sel_r = {2'd0, 2'd0};
        for (int l = 0; l < 4; l++) begin
            wr(0, l, 3 + 9 * l);
            rise_count(3 + 9 * l, n);
            chk(n == nstages(l), "R3", $sformatf("depth code %0d samples", l), n, nstages(l));
        end

        // R5: other counter bits cause no samples
        cur_req = "R5";
        wr(0, 0, 7);
        for (int i = 0; i < 4; i++) smp(7, 0);
        pin_r = '1;
        for (int i = 0; i < 20; i++) begin ct_r = ct_r ^ ~(32'h80); cyc(); end
        chk(level_out[0] == 0, "R5", "non-tap toggles", int'(level_out[0]), 0);
        smp(7, 1); smp(7, 1);
        chk(level_out[0] == 1, "R5", "tap toggles still sample", int'(level_out[0]), 1);

        // R6: short disagreement keeps output
        cur_req = "R6";
        wr(0, 2, 6);
        for (int i = 0; i < 8; i++) smp(6, 0);
        for (int i = 0; i < 4; i++) smp(6, 1);
        smp(6, 0);
        chk(level_out[0] == 0, "R6", "four ones then zero", int'(level_out[0]), 0);
        for (int i = 0; i < 4; i++) smp(6, 1);
        chk(level_out[0] == 0, "R6", "four ones after break", int'(level_out[0]), 0);
        smp(6, 1);
        chk(level_out[0] == 1, "R6", "fifth one", int'(level_out[0]), 1);
        smp(6, 0); smp(6, 1);
        chk(level_out[0] == 1, "R6", "single zero glitch held", int'(level_out[0]), 1);

        // R8: shrinking depth acts on the kept chain
        cur_req = "R8";
        wr(0, 3, 6);
        for (int i = 0; i < 8; i++) smp(6, 0);
        smp(6, 1); smp(6, 1);
        chk(level_out[0] == 0, "R8", "two ones at depth 8", int'(level_out[0]), 0);
        wr(0, 0, 6);
        cyc(); cyc();
        chk(level_out[0] == 1, "R8", "depth shrink to 2", int'(level_out[0]), 1);

        // R9: pins on different settings are independent
        cur_req = "R9";
        wr(0, 0, 2); wr(1, 3, 9);
        sel_r = {2'd1, 2'd0};
        pin_r = '0;
        for (int i = 0; i < 8; i++) begin ct_r[2] = ~ct_r[2]; ct_r[9] = ~ct_r[9]; cyc(); cyc(); end
        smp(2, 1); smp(2, 1);
        chk(level_out[0] == 1, "R9", "pin0 on tap 2", int'(level_out[0]), 1);
        chk(level_out[1] == 0, "R9", "pin1 on tap 9", int'(level_out[1]), 0);

        // R7: a write leaves other settings alone
        cur_req = "R7";
        wr(1, 1, 5);
        wr(2, 0, 1);
        sel_r = {2'd1, 2'd1};
        rise_count(5, n);
        chk(n == 3, "R7", "set1 after set2 write", n, 3);
        sel_r = {2'd2, 2'd2};
        rise_count(1, n);
        chk(n == 2, "R7", "set2 rewritten", n, 2);

        // R4: counting counter, tap 4, depth 2: rise seen after ct reaches 32
        cur_req = "R4";
        do_reset();
        sel_r = {2'd0, 2'd0};
        wr(0, 0, 4);
        pin_r = '1;
        first = 0;
        for (int k = 1; k <= 40; k++) begin
            ct_r = 32'(k);
            cyc();
            if (level_out[0] && first == 0) first = k;
        end
        chk(first == 33, "R4", "clock of first rise", first, 33);

        // R4/R6/R9 sweep: counting counter, pseudo-random pins and selects
        cur_req = "R4";
        for (int s = 0; s < 4; s++) wr(s, s, s);
        lf = 32'h1234_5678;
        for (int k = 0; k < 3000; k++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            ct_r = ct_r + 1;
            pin_r = (lf[7:0] < 8'd40) ? ~pin_r : pin_r;
            if (lf[15:8] == 8'd0) sel_r = lf[19:16];
            cyc();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule